// File: doc/BRIEF.md
# Programmable Synthesizer Divider and Phase/Frequency Detector

This block holds the digital part of a frequency synthesizer loop. A main divider counts a prescaled RF clock, and its ratio is a fixed base of 2176 plus a 7-bit programmed word. A reference divider counts the edges of a crystal clock, and its ratio of 4, 8, 12 or 16 is chosen by a 2-bit select. A phase/frequency detector compares the two divider outputs. It drives an up (source) pulse or a down (sink) pulse toward an external charge pump, and each pulse lasts as long as the two divider edges are apart in time.

The whole block runs on the RF clock. The crystal clock is much slower, so it is passed through a synchronizer and used as a count enable. Pulse widths are therefore counted in RF cycles. A synthesizer-enable input controls the loop. When it rises, the block waits for the next crystal edge and starts both dividers together from that edge, so the loop never begins with an arbitrary phase error. When it falls, any pulse already in progress runs until the divider edge that normally ends it, and only then does the block go quiet. The crystal clock must therefore keep running briefly after disable.

Top module: `pllSynthCore`

## Requirements
- R1: The main divider ratio is 2176 + mainWord, where mainWord is 7 bits wide (0..127). This gives ratios 2176..2303 in RF cycles.
- R2: The reference divider ratio is 4 × (refSel + 1) crystal periods: refSel 0 gives 4, 1 gives 8, 2 gives 12 and 3 gives 16.
- R3: When the reference divider edge comes first, pumpUp is high for exactly as many RF cycles as the reference edge leads the main edge.
- R4: When the main divider edge comes first, pumpDown is high for exactly as many RF cycles as the main edge leads the reference edge.
- R5: pumpUp and pumpDown are never high in the same cycle. When both divider edges arrive in the same cycle, neither output pulses.
- R6: After synthEn rises, both dividers start together on the next crystal edge. The first comparison error therefore depends only on the two ratios and not on when synthEn rose.
- R7: mainWord and refSel are captured when the loop starts. Changes while the loop is running have no effect until the next enable.
- R8: After synthEn falls, a pulse in progress keeps its full width and no new pulse starts.
- R9: While the loop is disabled (and during reset), pumpUp and pumpDown stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rfClk | input | 1 | Prescaled RF clock; clocks all logic and the main divider |
| rstN | input | 1 | Active-low synchronous reset |
| xtalClk | input | 1 | Crystal reference clock, sampled in the rfClk domain |
| mainWord | input | 7 | Main divider offset added to 2176 |
| refSel | input | 2 | Reference divider ratio select |
| synthEn | input | 1 | Loop enable; rise starts the loop, fall stops it cleanly |
| pumpUp | output | 1 | Charge-pump source pulse (reference edge leads) |
| pumpDown | output | 1 | Charge-pump sink pulse (main edge leads) |

## Verification
On every cycle, the assertions check four things. The two pump outputs never overlap. An up pulse ends only on a main divider tick, and a down pulse ends only on a reference tick, which also covers the drain after disable. No pulse appears once the enable has been low and the outputs quiet. No up pulse lasts longer than the largest main ratio. Only the bench scenarios can show the exact pulse widths for each ratio and select value. The same goes for how the phase error grows over successive comparisons, and for the first error staying the same when the enable is raised at different moments. The bench also shows that word changes in mid-run are ignored, and that a pulse cut by disable keeps its full programmed width.

// File: rtl/pllPkg.sv
package pllPkg;
  typedef struct packed {
    logic loadRatios;  // capture words and preset both counters
    logic countEn;     // counters advance
  } dpStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } loopState_t;
endpackage

// File: rtl/pllDivPath.sv
module pllDivPath
  import pllPkg::*;
#(
  parameter int MAIN_BASE   = 2176,
  parameter int MAIN_BITS   = 7,
  parameter int REF_STEP    = 4,
  parameter int SEL_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 rfClk,
  input  logic                 rstN,
  input  logic                 xtalClk,
  input  logic [MAIN_BITS-1:0] mainWord,
  input  logic [SEL_BITS-1:0]  refSel,
  input  dpStrobes_t           stb,
  output logic                 xtalEdge,
  output logic                 mainTick,
  output logic                 refTick
);
  localparam int MAIN_MAX   = MAIN_BASE + (1 << MAIN_BITS) - 1;
  localparam int MAIN_CNT_W = $clog2(MAIN_MAX + 1);
  localparam int REF_MAX    = REF_STEP * (1 << SEL_BITS);
  localparam int REF_CNT_W  = $clog2(REF_MAX + 1);

  // crystal synchronizer plus one delay stage for edge detection
  logic [SYNC_STAGES:0] xtalPipe;
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge rfClk) begin
          if (!rstN) xtalPipe[0] <= 1'b0;
          else       xtalPipe[0] <= xtalClk;
        end
      end else begin : g_next
        always_ff @(posedge rfClk) begin
          if (!rstN) xtalPipe[g] <= 1'b0;
          else       xtalPipe[g] <= xtalPipe[g-1];
        end
      end
    end
  endgenerate

  assign xtalEdge = xtalPipe[SYNC_STAGES-1] & ~xtalPipe[SYNC_STAGES];

  logic [MAIN_CNT_W-1:0] liveMain, mainRatioQ, mainCnt;
  logic [REF_CNT_W-1:0]  liveRef, refRatioQ, refCnt;

  assign liveMain = MAIN_CNT_W'(MAIN_BASE) + MAIN_CNT_W'(mainWord);
  assign liveRef  = REF_CNT_W'(REF_STEP) * (REF_CNT_W'(refSel) + REF_CNT_W'(1));

  assign mainTick = stb.countEn && (mainCnt == '0);
  assign refTick  = stb.countEn && xtalEdge && (refCnt == '0);

  always_ff @(posedge rfClk) begin
    if (!rstN) begin
      mainRatioQ <= MAIN_CNT_W'(MAIN_BASE);
      refRatioQ  <= REF_CNT_W'(REF_STEP);
      mainCnt    <= MAIN_CNT_W'(MAIN_BASE - 1);
      refCnt     <= REF_CNT_W'(REF_STEP - 1);
    end else if (stb.loadRatios) begin
      mainRatioQ <= liveMain;
      refRatioQ  <= liveRef;
      mainCnt    <= liveMain - MAIN_CNT_W'(1);
      refCnt     <= liveRef - REF_CNT_W'(1);
    end else if (stb.countEn) begin
      mainCnt <= mainTick ? mainRatioQ - MAIN_CNT_W'(1) : mainCnt - MAIN_CNT_W'(1);
      if (xtalEdge)
        refCnt <= refTick ? refRatioQ - REF_CNT_W'(1) : refCnt - REF_CNT_W'(1);
    end
  end
endmodule

// File: rtl/pllLoopCtrl.sv
module pllLoopCtrl
  import pllPkg::*;
(
  input  logic       rfClk,
  input  logic       rstN,
  input  logic       synthEn,
  input  logic       xtalEdge,
  input  logic       mainTick,
  input  logic       refTick,
  output dpStrobes_t stb,
  output logic       pumpUp,
  output logic       pumpDown
);
  loopState_t state, stateNext;
  logic allowStart, bothSeen, upNext, dnNext;

  always_comb begin
    stb.loadRatios = (state == ST_ARM) && synthEn && xtalEdge;
    stb.countEn    = (state == ST_RUN) || (state == ST_DRAIN);
    allowStart     = (state == ST_RUN);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (synthEn) stateNext = ST_ARM;
      ST_ARM:   if (!synthEn) stateNext = ST_IDLE;
                else if (xtalEdge) stateNext = ST_RUN;
      ST_RUN:   if (!synthEn) stateNext = ST_DRAIN;
      ST_DRAIN: if (!pumpUp && !pumpDown) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  // detector: an arriving edge either opens a pulse or cancels the opposite one
  always_comb begin
    bothSeen = (pumpUp | refTick) & (pumpDown | mainTick);
    upNext   = !bothSeen && (pumpUp   || (refTick  && allowStart));
    dnNext   = !bothSeen && (pumpDown || (mainTick && allowStart));
  end

  always_ff @(posedge rfClk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pumpUp   <= 1'b0;
      pumpDown <= 1'b0;
    end else begin
      state    <= stateNext;
      pumpUp   <= upNext && stb.countEn;
      pumpDown <= dnNext && stb.countEn;
    end
  end
endmodule

// File: rtl/pllSynthCore.sv
module pllSynthCore
  import pllPkg::*;
#(
  parameter int MAIN_BASE   = 2176,
  parameter int MAIN_BITS   = 7,
  parameter int REF_STEP    = 4,
  parameter int SEL_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 rfClk,
  input  logic                 rstN,
  input  logic                 xtalClk,
  input  logic [MAIN_BITS-1:0] mainWord,
  input  logic [SEL_BITS-1:0]  refSel,
  input  logic                 synthEn,
  output logic                 pumpUp,
  output logic                 pumpDown
);
  dpStrobes_t stb;
  logic xtalEdge, mainTick, refTick;

  pllDivPath #(
    .MAIN_BASE(MAIN_BASE), .MAIN_BITS(MAIN_BITS), .REF_STEP(REF_STEP),
    .SEL_BITS(SEL_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) i_divPath (
    .rfClk(rfClk), .rstN(rstN), .xtalClk(xtalClk),
    .mainWord(mainWord), .refSel(refSel), .stb(stb),
    .xtalEdge(xtalEdge), .mainTick(mainTick), .refTick(refTick)
  );

  pllLoopCtrl i_loopCtrl (
    .rfClk(rfClk), .rstN(rstN), .synthEn(synthEn),
    .xtalEdge(xtalEdge), .mainTick(mainTick), .refTick(refTick),
    .stb(stb), .pumpUp(pumpUp), .pumpDown(pumpDown)
  );
endmodule

// File: rtl/pllSynthChecker.sv
module pllSynthChecker #(
  parameter int MAIN_BASE = 2176,
  parameter int MAIN_BITS = 7
) (
  input logic rfClk,
  input logic rstN,
  input logic synthEn,
  input logic pumpUp,
  input logic pumpDown,
  input logic mainTick,
  input logic refTick
);
  localparam int MAIN_MAX = MAIN_BASE + (1 << MAIN_BITS) - 1;

  logic [1:0] sinceRst;
  int unsigned upRun;

  always_ff @(posedge rfClk) begin
    if (!rstN) begin
      sinceRst <= '0;
      upRun    <= 0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
      upRun <= pumpUp ? upRun + 1 : 0;
    end
  end

  // R5: the outputs are mutually exclusive
  a_r5_no_overlap: assert property (@(posedge rfClk) disable iff (!rstN)
    !(pumpUp && pumpDown));

  // R8: an up pulse is closed only by a main edge, even while draining
  a_r8_up_ends_on_main: assert property (@(posedge rfClk) disable iff (!rstN)
    $fell(pumpUp) |-> $past(mainTick));

  // R8: a down pulse is closed only by a reference edge
  a_r8_dn_ends_on_ref: assert property (@(posedge rfClk) disable iff (!rstN)
    $fell(pumpDown) |-> $past(refTick));

  // R9: once disabled and quiet, the outputs stay low
  a_r9_idle_quiet: assert property (@(posedge rfClk) disable iff (!rstN)
    (sinceRst >= 2'd2 && !$past(synthEn, 1) && !$past(synthEn, 2)
     && !$past(pumpUp) && !$past(pumpDown)) |-> (!pumpUp && !pumpDown));

  // R3: an up pulse never outlasts one full main period
  a_r3_up_bounded: assert property (@(posedge rfClk) disable iff (!rstN)
    upRun <= MAIN_MAX);
endmodule

bind pllSynthCore pllSynthChecker #(.MAIN_BASE(MAIN_BASE), .MAIN_BITS(MAIN_BITS)) i_pllSynthChecker (
  .rfClk(rfClk), .rstN(rstN), .synthEn(synthEn), .pumpUp(pumpUp),
  .pumpDown(pumpDown), .mainTick(mainTick), .refTick(refTick)
);

// File: tb/test_pllSynthCore.sv
module test_pllSynthCore;
  logic       rfClk = 1'b0;
  logic       rstN = 1'b0;
  logic       xtalClk = 1'b0;
  logic       synthEn = 1'b0;
  logic [6:0] mainWord = '0;
  logic [1:0] refSel = '0;
  logic       pumpUp, pumpDown;

  int xtalHalf = 272;
  int xtalCnt = 0;
  int checks = 0;
  int errors = 0;

  pllSynthCore i_pllSynthCore (
    .rfClk(rfClk), .rstN(rstN), .xtalClk(xtalClk), .mainWord(mainWord),
    .refSel(refSel), .synthEn(synthEn), .pumpUp(pumpUp), .pumpDown(pumpDown)
  );

  always #10 rfClk = ~rfClk;  // 50 MHz

  // crystal clock: period of 2*xtalHalf RF cycles
  always @(posedge rfClk) begin
    if (xtalCnt >= xtalHalf - 1) begin
      xtalCnt <= 0;
      xtalClk <= ~xtalClk;
    end else begin
      xtalCnt <= xtalCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic awaitPulse(input int limit, output bit found, output bit isUp,
                            output int width);
    found = 0; isUp = 0; width = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge rfClk);
      if (pumpUp || pumpDown) begin found = 1; isUp = pumpUp; break; end
    end
    if (found) begin
      while ((isUp ? pumpUp : pumpDown) && width < 5000) begin
        width++;
        @(negedge rfClk);
      end
    end
  endtask

  task automatic watchQuiet(input int n, output bit seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge rfClk);
      if (pumpUp || pumpDown) seen = 1;
    end
  endtask

  task automatic stopLoop();
    @(negedge rfClk);
    synthEn = 1'b0;
    @(negedge rfClk);
    while (pumpUp || pumpDown) @(negedge rfClk);
    repeat (4) @(negedge rfClk);
  endtask

  task automatic setup(input int half, input int sel, input int word, input int pre);
    @(negedge rfClk);
    synthEn  = 1'b0;
    xtalHalf = half;
    refSel   = 2'(sel);
    mainWord = 7'(word);
    repeat (5 + pre) @(negedge rfClk);
    synthEn = 1'b1;
  endtask

  // first two comparisons: error e, then 2e
  task automatic runCompare(input int half, input int sel, input int word, input int pre,
                            input bit expUp, input int expW, input string req);
    bit found, isUp;
    int width;
    setup(half, sel, word, pre);
    awaitPulse(20000, found, isUp, width);
    check(found, req, "first pulse seen", int'(found), 1);
    check(isUp == expUp, req, "pulse direction up", int'(isUp), int'(expUp));
    check(width == expW, req, "first pulse width", width, expW);
    awaitPulse(20000, found, isUp, width);
    check(found && width == 2 * expW, req, "second pulse width", width, 2 * expW);
    stopLoop();
  endtask

  task automatic testReset();
    bit seen;
    check(!pumpUp && !pumpDown, "R9", "outputs in reset", int'(pumpUp | pumpDown), 0);
    repeat (5) @(negedge rfClk);
    rstN = 1'b1;
    watchQuiet(3000, seen);
    check(!seen, "R9", "pulse while disabled", int'(seen), 0);
  endtask

  task automatic testLocked();
    bit seen;
    setup(272, 0, 0, 0);  // 2176 vs 4*544
    watchQuiet(7000, seen);
    check(!seen, "R5", "pulse at equal arrival", int'(seen), 0);
    stopLoop();
  endtask

  task automatic testWordChange();
    bit seen, found, isUp;
    int width;
    setup(272, 0, 0, 0);
    repeat (500) @(negedge rfClk);
    mainWord = 7'd50;
    watchQuiet(7000, seen);
    check(!seen, "R7", "pulse after mid-run word change", int'(seen), 0);
    stopLoop();
    synthEn = 1'b1;
    awaitPulse(20000, found, isUp, width);
    check(found && isUp && width == 50, "R7", "up width after re-enable", width, 50);
    stopLoop();
  endtask

  task automatic testDrain();
    bit found, isUp, seen;
    int width;
    setup(68, 3, 127, 0);  // ref 16*136=2176, main 2303
    found = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge rfClk);
      if (pumpUp) begin found = 1; break; end
    end
    width = 0;
    while (pumpUp && width < 5000) begin
      width++;
      if (width == 20) synthEn = 1'b0;
      @(negedge rfClk);
    end
    check(found && width == 127, "R8", "width of pulse cut by disable", width, 127);
    watchQuiet(6000, seen);
    check(!seen, "R8", "new pulse after disable", int'(seen), 0);
    check(!pumpUp && !pumpDown, "R9", "outputs after drain", int'(pumpUp | pumpDown), 0);
  endtask

  initial begin
    repeat (190000) @(posedge rfClk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    runCompare(272, 0, 5,   0,   1'b1, 5,   "R3");  // 2176 vs 2181
    runCompare(272, 0, 5,   137, 1'b1, 5,   "R6");
    runCompare(272, 0, 5,   401, 1'b1, 5,   "R6");
    runCompare(275, 0, 10,  0,   1'b0, 14,  "R4");  // 2200 vs 2186
    runCompare(136, 1, 3,   0,   1'b1, 3,   "R2");  // 8*272 vs 2179
    runCompare(91,  2, 0,   0,   1'b0, 8,   "R2");  // 12*182 vs 2176
    runCompare(68,  3, 127, 0,   1'b1, 127, "R1");  // 16*136 vs 2303
    testLocked();
    testWordChange();
    testDrain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule